// File: doc/BRIEF.md
# Edge-Latching Interrupt Collector with Register Access

The block gathers thirty-two interrupt request lines into one summary request for a host processor. Every line is brought into the clock domain by a two-stage synchroniser. A rising edge on a line records an event in a pending register. An enable register chooses which of the recorded events may drive the registered summary output. Software reaches both registers through a simple single-cycle register port. Writes take effect at the clock edge on which the strobe is sampled. Read data appears one cycle after the read strobe.

Clearing works by a masked write-back. Software reads the pending word and drops the bit it has serviced. It then writes the word back, and any bit written as zero clears. A bit written as one keeps its current value and can never be set by software. When a new edge arrives in the same cycle as a clear of that bit, the edge wins, so no event is lost. Writing an all-zero word clears every event, which is the start-up step.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the enable register reads 0x00000000, the pending register reads 0x00000000, irq_o is 0 and bus_rdata is 0.
- R2: A low-to-high transition on src_i[n] sets pending bit n. The bit is visible to a read issued three clock edges after the edge that first samples the new level. A line held high produces only one event, so once cleared the bit stays clear until the line falls and rises again.
- R3: A write to byte offset 0x00 loads the whole enable register from bus_wdata. A read of 0x00 returns it, and bit n of it enables source n.
- R4: A write to byte offset 0x10 clears every pending bit whose bus_wdata bit is 0 and leaves every pending bit whose bus_wdata bit is 1 unchanged.
- R5: Writing 1 to a pending bit that is 0 leaves it at 0. Only a source edge sets a pending bit.
- R6: When a source edge and a write of 0 to the same pending bit fall in the same cycle, the bit ends set.
- R7: irq_o is a register that equals, one clock later, the OR over all bits of (pending AND enable).
- R8: bus_rdata holds the addressed register value one cycle after a cycle with bus_rd high. It is zero after a read of any offset other than 0x00 or 0x10, and zero after any cycle without a read.
- R9: Writing 0x00000000 to offset 0x10 clears all pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt request lines, rising edge active |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered summary interrupt to the host |

## Verification
The assertions check on every cycle the following properties:
- the synchroniser's edge pulse lasts a single cycle;
- a pending bit never rises without an edge;
- an edge always leaves its bit set, whatever write happens alongside it;
- a zero written to a pending bit clears it;
- the summary output follows pending AND enable one cycle later;
- reads of unmapped offsets return zero.

Only the bench's scenarios can show the end-to-end behaviour. One is the latency from a pin to a readable bit. Another is that a held line is counted once. A third is the read-mask-write clearing sequence as software uses it. The last is the exact cycle alignment of a clear that collides with an arriving edge.

// File: rtl/irq_collector_pkg.sv
// Shared constants for the interrupt collector.
// Assumes a 32-bit register word and byte offsets on an 8-bit address.
package irq_collector_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OFS_W      = 8;
    localparam logic [7:0]  OFS_ENABLE = 8'h00;
    localparam logic [7:0]  OFS_EVENTS = 8'h10;

    // Register selected by a bus offset.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_EVENTS = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
// Brings each request line into the clock domain through two flops.
// A third flop holds the previous level so that a one-cycle pulse
// marks every rising edge.
// Assumes each input stays high for at least two clock periods.
module irq_edge_sync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Two synchronising stages and one history stage for line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= line_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
    end

    // R2: an edge pulse never lasts two cycles in a row.
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_event_bank.sv
// Pending event register. A hardware edge sets a bit. A bus write
// clears only the bits written as zero. The set has priority over
// a clear in the same cycle.
// Assumes keep_i is valid only while clr_we_i is high.
module irq_event_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;

    // Next state: keep-mask on a write, then OR in new edges.
    always_comb begin
        pend_d = pend_q;
        if (clr_we_i) begin
            pend_d = pend_q & keep_i;
        end
        pend_d = pend_d | rise_i;
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R5: a bit that was clear only rises after an edge.
    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0));
    // R6: an edge always leaves its bit set, with or without a write.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
    // R4: bits written as zero, with no edge, end clear.
    p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((pend_q & ~$past(keep_i) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/irq_reg_port.sv
// Register port. It decodes the offset, holds the enable register,
// produces the write strobe for the pending bank and registers the
// read data. Data is valid one cycle after a read. When no read is
// made, the read data is zero.
// Assumes single-cycle strobes and exact offset matching.
module irq_reg_port
    import irq_collector_pkg::*;
#(
    parameter int unsigned N       = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ENA_OFS = ADDR_W'(OFS_ENABLE),
    parameter logic [ADDR_W-1:0] PND_OFS = ADDR_W'(OFS_EVENTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      pend_i,
    output logic [N-1:0]      en_o,
    output logic              pnd_we_o,
    output logic [N-1:0]      rdata_o
);
    reg_sel_e     sel;
    logic [N-1:0] en_q;
    logic [N-1:0] rdata_q;
    logic [N-1:0] rd_mux;

    // Offset decode.
    always_comb begin
        if (addr_i == ENA_OFS)      sel = SEL_ENABLE;
        else if (addr_i == PND_OFS) sel = SEL_EVENTS;
        else                        sel = SEL_NONE;
    end

    // Read data selection, zero for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_ENABLE: rd_mux = en_q;
            SEL_EVENTS: rd_mux = pend_i;
            default:    rd_mux = '0;
        endcase
    end

    // Enable register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_i && sel == SEL_ENABLE) begin
            en_q <= wdata_i;
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_i ? rd_mux : '0;
        end
    end

    assign pnd_we_o = wr_i && (sel == SEL_EVENTS);
    assign en_o     = en_q;
    assign rdata_o  = rdata_q;

    // R3: a write to the enable offset loads the whole word.
    p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ENA_OFS) |=> (en_o == $past(wdata_i)));
    // R8: no read, or an unmapped read, gives zero data.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i || (addr_i != ENA_OFS && addr_i != PND_OFS)) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_summary.sv
// Registered summary request: high while any enabled event is pending.
// Assumes pend_i and en_i come straight from registers.
module irq_summary #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;

    // Reduce the enabled events into one flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_i & en_i);
        end
    end

    assign irq_o = irq_q;

    // R7: the output follows the enabled pending events one cycle later.
    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_i & en_i))));
endmodule

// File: rtl/irq_collector.sv
// Top of the interrupt collector. It connects the synchroniser, the
// event bank, the register port and the summary flop.
// Assumes one bus operation per cycle and request lines that are
// asynchronous to clk.
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int unsigned N      = WORD_W,
    parameter int unsigned ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq_o
);
    logic [N-1:0] rise;
    logic [N-1:0] pend;
    logic [N-1:0] en;
    logic         pnd_we;

    irq_edge_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (src_i),
        .rise_o (rise)
    );

    irq_event_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .clr_we_i (pnd_we),
        .keep_i   (bus_wdata),
        .pend_o   (pend)
    );

    irq_reg_port #(
        .N       (N),
        .ADDR_W  (ADDR_W),
        .ENA_OFS (ADDR_W'(OFS_ENABLE)),
        .PND_OFS (ADDR_W'(OFS_EVENTS))
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .pend_i   (pend),
        .en_o     (en),
        .pnd_we_o (pnd_we),
        .rdata_o  (bus_rdata)
    );

    irq_summary #(.N(N)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .en_i   (en),
        .irq_o  (irq_o)
    );
endmodule

// File: tb/irq_collector_test.sv
`timescale 1ns/1ps
module irq_collector_test;
    localparam logic [7:0] A_EN  = 8'h00;
    localparam logic [7:0] A_PND = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_en = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_collector uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    function automatic logic exp_irq(input logic [31:0] p, input logic [31:0] e);
        return |(p & e);
    endfunction

    function automatic logic [31:0] exp_clear(input logic [31:0] p, input logic [31:0] d);
        return p & d;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    // Raise the masked lines, hold them, drop them again.
    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        src = src | m;
        repeat (4) @(negedge clk);
        src = src & ~m;
        m_pend = m_pend | m;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        bus_read(A_PND, v);
        check({req, " pending"}, v, m_pend);
        bus_read(A_EN, v);
        check({req, " enable"}, v, m_en);
        check({req, " irq R7"}, {31'b0, irq}, {31'b0, exp_irq(m_pend, m_en)});
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check_regs("R1");

        // R3: enable register load and readback
        m_en = 32'hA5A5_0F0F;
        bus_write(A_EN, m_en);
        check_regs("R3");

        // R2: single edge sets a pending bit; R7 summary follows
        pulse(32'h0000_0001);
        check_regs("R2 edge");
        // R2 latency: the bit is not yet readable two edges after sampling
        @(negedge clk);
        src[4] = 1'b1;
        @(negedge clk);
        bus_read(A_PND, v);
        check("R2 latency early", v & 32'h10, 32'h0);
        bus_read(A_PND, v);
        check("R2 latency late", v & 32'h10, 32'h10);
        m_pend = m_pend | 32'h10;
        // R2: held line counts once
        bus_write(A_PND, ~32'h10);
        m_pend = exp_clear(m_pend, ~32'h10);
        repeat (6) @(negedge clk);
        check_regs("R2 held line");
        src[4] = 1'b0;
        repeat (3) @(negedge clk);

        // R4: read-mask-write clears one bit and keeps others
        pulse(32'h0300_0100);
        bus_read(A_PND, v);
        bus_write(A_PND, v & ~32'h0000_0100);
        m_pend = exp_clear(m_pend, ~32'h0000_0100);
        check_regs("R4");

        // R5: writing ones does not set bits
        bus_write(A_PND, 32'hFFFF_FFFF);
        check_regs("R5");

        // R6: edge collides with a clear of the same bit
        pulse(32'h0000_0040);
        @(negedge clk);
        src[6] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr = 1'b1; addr = A_PND; wdata = ~32'h0000_0041;
        @(negedge clk);
        wr = 1'b0;
        m_pend = (m_pend & ~32'h0000_0041) | 32'h0000_0040;
        src[6] = 1'b0;
        repeat (3) @(negedge clk);
        check_regs("R6");

        // R8: unmapped offsets read as zero, idle data is zero
        bus_read(8'h04, v);
        check("R8 ofs 0x04", v, 32'h0);
        bus_read(8'h14, v);
        check("R8 ofs 0x14", v, 32'h0);
        bus_read(8'h80, v);
        check("R8 ofs 0x80", v, 32'h0);
        @(negedge clk);
        check("R8 idle", rdata, 32'h0);

        // R9: all-zero write clears everything
        pulse(32'hF000_000F);
        bus_write(A_PND, 32'h0);
        m_pend = '0;
        check_regs("R9");

        // R7: random mix of edges, enable changes and clears
        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom_range(0, 2));
            if (op == 0) begin
                pulse($urandom());
            end else if (op == 1) begin
                m_en = $urandom();
                bus_write(A_EN, m_en);
                @(negedge clk);
            end else begin
                v = $urandom() | $urandom();
                bus_write(A_PND, v);
                m_pend = exp_clear(m_pend, v);
                @(negedge clk);
            end
            check_regs("R7 random");
        end

        // R7: enabled event then masked off drops irq
        m_en = '0;
        bus_write(A_EN, 32'h0);
        @(negedge clk);
        check("R7 masked", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule